// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This peripheral lets several processors on one chip pass short messages to each other through a bank of mailboxes. A processor claims a mailbox by writing its own channel bit into the owner field. It then picks the receiving channels and the channels allowed to interrupt, fills up to seven data words, and writes a send code. Each receiving channel whose mask bit is set gets an interrupt. The receiver reads the words and writes the acknowledge code, which interrupts the owner. Writing the idle code ends the exchange, and writing zero to the owner field frees the mailbox.

Every processor channel has its own interrupt line. It also has two status words with one bit per mailbox: one holds the raw pending state and the other the same state after the mask. The register port is a plain APB-style interface. Writes take effect at the clock edge that closes the access phase. Read data is driven combinationally during the access phase.

Top module: `mbx_hub`

## Requirements
- R1: While reset is held and right after it, all owner, destination, mask, handshake and data state reads zero and every interrupt output is low.
- R2: The owner field (word 0 of a mailbox) takes a nonzero write only while it is zero. Writing zero frees the mailbox and also clears its destination set, mask set and handshake state.
- R3: The destination and mask sets are changed only by write-one operations. A 1 at bit n of the set word (word 1 for destinations, word 5 for masks) sets channel n, and a 1 in the matching clear word (words 2 and 6) clears it. Zero bits have no effect. The current sets read back at words 3 and 7.
- R4: Each mailbox holds seven independent 32-bit data words at byte offsets 0x24 to 0x3C of its block. Each word can be written and read back.
- R5: Writing handshake code 1 to word 8 (offset 0x20) puts the mailbox in the sent state. Its raw pending bit is then set for every destination channel.
- R6: Writing handshake code 2 puts the mailbox in the acknowledged state. Its raw pending bit is then set for the owner channel only, and not for the destinations.
- R7: Writing code 0 returns the handshake to idle and removes every pending bit of the mailbox. Writing code 3 leaves the handshake state unchanged. The current code reads back at word 8.
- R8: A masked pending bit equals the raw bit ANDed with that mailbox's mask bit for the channel. The interrupt of channel n is the OR of its masked bits. Changing a mask does not alter raw bits.
- R9: For channel n, the masked status word is at byte 0x800 + 8n and the raw status word at 0x804 + 8n. Bit m of each word refers to mailbox m.
- R10: Mailbox m occupies bytes 64m to 64m+63, and mailboxes keep separate state. Reads of the mode word (offset 0x10), of blocks beyond the last mailbox, and of status words beyond the last channel return zero. Writes to them change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid during the access phase |
| irq | output | NUM_CHAN (8) | One interrupt line per processor channel |

## Verification
A write changes mailbox state at the rising edge that ends its access phase. The interrupt lines and both status words are pure logic from that state, so they show the new value in the same cycle, one edge after the access phase began. Read data belongs to the access phase itself. The bench drives inputs just after a rising edge and samples `prdata` and `irq` at the falling edge. A read is compared on the falling edge inside its own access phase, and an interrupt is compared on the first falling edge after the write's closing edge. The scoreboard queue therefore never holds more than one outstanding expectation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // data words carried by one mailbox
    localparam int WORDS_PER_MBOX = 7;
    // word-index width inside a 64-byte mailbox block
    localparam int FIELD_W = 4;

    // word index (byte offset / 4) inside a mailbox block
    typedef enum logic [FIELD_W-1:0] {
        F_OWNER    = 4'd0,
        F_DST_SET  = 4'd1,
        F_DST_CLR  = 4'd2,
        F_DST_STAT = 4'd3,
        F_MODE     = 4'd4,
        F_MSK_SET  = 4'd5,
        F_MSK_CLR  = 4'd6,
        F_MSK_STAT = 4'd7,
        F_SEND     = 4'd8,
        F_DATA0    = 4'd9
    } field_e;

    // handshake codes written to the send word
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SENT  = 2'd1,
        HS_ACKED = 2'd2
    } hs_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    output logic                wr_fire,
    output logic [NUM_MBOX-1:0] mbox_hit,
    output logic [NUM_CHAN-1:0] chan_hit,
    output logic                stat_raw,
    output logic [3:0]          field
);
    // upper half of the map holds status words, lower half mailbox blocks
    localparam int MBI_W = ADDR_W - 7;
    localparam int CHI_W = ADDR_W - 4;

    logic region_stat;
    logic unused_low;

    assign region_stat = paddr[ADDR_W-1];
    assign wr_fire     = psel && penable && pwrite;
    assign field       = paddr[5:2];
    assign stat_raw    = paddr[2];
    assign unused_low  = ^paddr[1:0];

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox_hit
        assign mbox_hit[m] = !region_stat && (paddr[ADDR_W-2:6] == MBI_W'(m));
    end

    for (genvar n = 0; n < NUM_CHAN; n++) begin : g_chan_hit
        assign chan_hit[n] = region_stat && (paddr[ADDR_W-2:3] == CHI_W'(n));
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          field,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_CHAN-1:0] owner_o,
    output logic [NUM_CHAN-1:0] dst_o,
    output logic [NUM_CHAN-1:0] msk_o,
    output logic [1:0]          hs_o,
    output logic [NUM_CHAN-1:0] raw_o,
    output logic [NUM_CHAN-1:0] masked_o
);
    typedef struct packed {
        logic [NUM_CHAN-1:0]                    owner;
        logic [NUM_CHAN-1:0]                    dst;
        logic [NUM_CHAN-1:0]                    msk;
        hs_e                                    hs;
        logic [WORDS_PER_MBOX-1:0][DATA_W-1:0]  data;
    } slot_t;

    slot_t               st_d, st_q;
    logic [NUM_CHAN-1:0] wr_bits;

    assign wr_bits = wr_data[NUM_CHAN-1:0];

    // next-state process
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (field)
                F_OWNER: begin
                    if (wr_bits == '0) begin
                        st_d.owner = '0;
                        st_d.dst   = '0;
                        st_d.msk   = '0;
                        st_d.hs    = HS_IDLE;
                    end else if (st_q.owner == '0) begin
                        st_d.owner = wr_bits;
                    end
                end
                F_DST_SET: st_d.dst = st_q.dst | wr_bits;
                F_DST_CLR: st_d.dst = st_q.dst & ~wr_bits;
                F_MSK_SET: st_d.msk = st_q.msk | wr_bits;
                F_MSK_CLR: st_d.msk = st_q.msk & ~wr_bits;
                F_SEND: begin
                    case (wr_data[1:0])
                        2'd0:    st_d.hs = HS_IDLE;
                        2'd1:    st_d.hs = HS_SENT;
                        2'd2:    st_d.hs = HS_ACKED;
                        default: st_d.hs = st_q.hs;
                    endcase
                end
                default: begin
                    for (int k = 0; k < WORDS_PER_MBOX; k++) begin
                        if (int'(field) == int'(F_DATA0) + k) begin
                            st_d.data[k] = wr_data;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // register read view
    always_comb begin
        rd_data = '0;
        case (field)
            F_OWNER:    rd_data = DATA_W'(st_q.owner);
            F_DST_STAT: rd_data = DATA_W'(st_q.dst);
            F_MSK_STAT: rd_data = DATA_W'(st_q.msk);
            F_SEND:     rd_data = {{(DATA_W-2){1'b0}}, st_q.hs};
            default: begin
                for (int k = 0; k < WORDS_PER_MBOX; k++) begin
                    if (int'(field) == int'(F_DATA0) + k) begin
                        rd_data = st_q.data[k];
                    end
                end
            end
        endcase
    end

    // pending bits: sent rings destinations, acknowledged rings the owner
    always_comb begin
        case (st_q.hs)
            HS_SENT:  raw_o = st_q.dst;
            HS_ACKED: raw_o = st_q.owner;
            default:  raw_o = '0;
        endcase
    end

    assign masked_o = raw_o & st_q.msk;
    assign owner_o  = st_q.owner;
    assign dst_o    = st_q.dst;
    assign msk_o    = st_q.msk;
    assign hs_o     = st_q.hs;

endmodule

// File: rtl/mbx_irq_map.sv
module mbx_irq_map #(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 8
) (
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] raw_mb,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] masked_mb,
    output logic [NUM_CHAN-1:0][NUM_MBOX-1:0] raw_ch,
    output logic [NUM_CHAN-1:0][NUM_MBOX-1:0] masked_ch,
    output logic [NUM_CHAN-1:0]               irq_o
);
    // turn per-mailbox channel vectors into per-channel mailbox vectors
    for (genvar n = 0; n < NUM_CHAN; n++) begin : g_chan
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
            assign raw_ch[n][m]    = raw_mb[m][n];
            assign masked_ch[n][m] = masked_mb[m][n];
        end
        assign irq_o[n] = |masked_ch[n];
    end

endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    output logic [NUM_CHAN-1:0] irq
);
    logic                              wr_fire;
    logic [NUM_MBOX-1:0]               mbox_hit;
    logic [NUM_CHAN-1:0]               chan_hit;
    logic                              stat_raw;
    logic [FIELD_W-1:0]                field;

    logic [NUM_MBOX-1:0][DATA_W-1:0]   slot_rd;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0] src_all;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0] dst_all;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0] msk_all;
    logic [NUM_MBOX-1:0][1:0]          hs_all;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0] raw_mb;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0] masked_mb;
    logic [NUM_CHAN-1:0][NUM_MBOX-1:0] raw_ch;
    logic [NUM_CHAN-1:0][NUM_MBOX-1:0] masked_ch;

    mbx_decode #(
        .NUM_MBOX (NUM_MBOX),
        .NUM_CHAN (NUM_CHAN),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .wr_fire  (wr_fire),
        .mbox_hit (mbox_hit),
        .chan_hit (chan_hit),
        .stat_raw (stat_raw),
        .field    (field)
    );

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
        mbx_slot #(
            .NUM_CHAN (NUM_CHAN),
            .DATA_W   (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_fire && mbox_hit[m]),
            .field    (field),
            .wr_data  (pwdata),
            .rd_data  (slot_rd[m]),
            .owner_o  (src_all[m]),
            .dst_o    (dst_all[m]),
            .msk_o    (msk_all[m]),
            .hs_o     (hs_all[m]),
            .raw_o    (raw_mb[m]),
            .masked_o (masked_mb[m])
        );
    end

    mbx_irq_map #(
        .NUM_MBOX (NUM_MBOX),
        .NUM_CHAN (NUM_CHAN)
    ) u_irq (
        .raw_mb    (raw_mb),
        .masked_mb (masked_mb),
        .raw_ch    (raw_ch),
        .masked_ch (masked_ch),
        .irq_o     (irq)
    );

    // read multiplexer; unmatched addresses return zero
    always_comb begin
        prdata = '0;
        for (int m = 0; m < NUM_MBOX; m++) begin
            if (mbox_hit[m]) begin
                prdata = slot_rd[m];
            end
        end
        for (int n = 0; n < NUM_CHAN; n++) begin
            if (chan_hit[n]) begin
                prdata = stat_raw ? DATA_W'(raw_ch[n]) : DATA_W'(masked_ch[n]);
            end
        end
    end

endmodule

// File: rtl/mbx_hub_chk.sv
module mbx_hub_chk #(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              psel,
    input  logic                              penable,
    input  logic                              pwrite,
    input  logic [ADDR_W-1:0]                 paddr,
    input  logic [DATA_W-1:0]                 pwdata,
    input  logic [NUM_CHAN-1:0]               irq,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] src_all,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] dst_all,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] msk_all,
    input  logic [NUM_MBOX-1:0][1:0]          hs_all
);
    localparam int MBI_W = ADDR_W - 7;

    logic wr;
    logic any_busy;
    logic unused_chk;

    assign wr         = psel && penable && pwrite;
    assign unused_chk = ^{pwdata, paddr};

    always_comb begin
        any_busy = 1'b0;
        for (int m = 0; m < NUM_MBOX; m++) begin
            any_busy = any_busy || (hs_all[m] != 2'd0);
        end
    end

    AST_RST_IRQ_LOW: assert property (@(posedge clk) !rst_n |-> irq == '0); // R1

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !any_busy |-> irq == '0); // R7

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
        logic hit_owner;
        logic hit_send;

        assign hit_owner = wr && !paddr[ADDR_W-1] && (paddr[ADDR_W-2:6] == MBI_W'(m))
                           && (paddr[5:2] == 4'd0);
        assign hit_send  = wr && !paddr[ADDR_W-1] && (paddr[ADDR_W-2:6] == MBI_W'(m))
                           && (paddr[5:2] == 4'd8);

        AST_OWNER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (src_all[m] != '0 && !(hit_owner && pwdata[NUM_CHAN-1:0] == '0))
            |=> $stable(src_all[m])); // R2

        AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_owner && pwdata[NUM_CHAN-1:0] == '0)
            |=> (hs_all[m] == 2'd0 && dst_all[m] == '0 && msk_all[m] == '0)); // R2

        AST_BAD_CODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_send && pwdata[1:0] == 2'd3) |=> $stable(hs_all[m])); // R7

        AST_SENT_RINGS_DST: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_all[m] == 2'd1)
            |-> ((irq & dst_all[m] & msk_all[m]) == (dst_all[m] & msk_all[m]))); // R5

        AST_ACK_RINGS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_all[m] == 2'd2)
            |-> ((irq & src_all[m] & msk_all[m]) == (src_all[m] & msk_all[m]))); // R6
    end

endmodule

bind mbx_hub mbx_hub_chk #(
    .NUM_MBOX (NUM_MBOX),
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .irq     (irq),
    .src_all (src_all),
    .dst_all (dst_all),
    .msk_all (msk_all),
    .hs_all  (hs_all)
);

// File: tb/tb_mbx_hub.sv
`timescale 1ns/100ps
module tb_mbx_hub;
    localparam int NM = 8;
    localparam int NC = 8;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_hub #(.NUM_MBOX(NM), .NUM_CHAN(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    // scoreboard of expected read results
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_exp[$];
    string         q_tag[$];

    function automatic logic [AW-1:0] fld(int m, int w);
        return AW'(m * 64 + w * 4);
    endfunction

    function automatic logic [AW-1:0] stw(int n, int raw);
        return AW'(32'h800 + n * 8 + raw * 4);
    endfunction

    task automatic bus(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = w; penable = 1'b0; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus(1'b1, a, d);
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        bus(1'b0, a, '0);
    endtask

    task automatic check_irq(input logic [NC-1:0] e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%h expected=%h", tag, irq, e);
        end
    endtask

    // monitor: compares each read in its access phase
    always @(negedge clk) begin : mon
        logic [AW-1:0] a;
        logic [DW-1:0] e;
        string         t;
        if (psel && penable && !pwrite) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL unexpected read addr=%h actual=%h expected=none", paddr, prdata);
            end else begin
                a = q_addr.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (prdata !== e) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, prdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        check_irq('0, "R1 irq in reset");
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_expect(fld(1, 0), 32'h0, "R1 owner after reset");
        rd_expect(fld(1, 9), 32'h0, "R1 data after reset");
        rd_expect(stw(2, 1), 32'h0, "R1 raw status after reset");
        check_irq('0, "R1 irq after reset");

        // R2: claim and lock of mailbox 1 by channel 1
        wr(fld(1, 0), 32'h02);
        rd_expect(fld(1, 0), 32'h02, "R2 claim accepted");
        wr(fld(1, 0), 32'h04);
        rd_expect(fld(1, 0), 32'h02, "R2 second claim ignored");

        // R3: write-one set and clear
        wr(fld(1, 1), 32'h0C);
        wr(fld(1, 2), 32'h08);
        rd_expect(fld(1, 3), 32'h04, "R3 dst set then clear");
        wr(fld(1, 1), 32'h00);
        rd_expect(fld(1, 3), 32'h04, "R3 zero set no effect");
        wr(fld(1, 5), 32'h06);
        wr(fld(1, 6), 32'h00);
        rd_expect(fld(1, 7), 32'h06, "R3 mask set, zero clear");

        // R4: seven data words
        for (int k = 0; k < 7; k++) wr(fld(1, 9 + k), 32'hC0DE_0000 + DW'(k));
        for (int k = 0; k < 7; k++) rd_expect(fld(1, 9 + k), 32'hC0DE_0000 + DW'(k), "R4 data word");
        check_irq('0, "R5 no irq before send");

        // R5 / R9: send rings destination channel 2
        wr(fld(1, 8), 32'h1);
        check_irq(8'h04, "R5 send rings destination");
        rd_expect(fld(1, 8), 32'h1, "R7 send code readback");
        rd_expect(stw(2, 0), 32'h02, "R9 masked status ch2");
        rd_expect(stw(2, 1), 32'h02, "R9 raw status ch2");
        rd_expect(stw(1, 1), 32'h00, "R5 owner not raw in sent");

        // R8: mask gating
        wr(fld(1, 6), 32'h04);
        check_irq(8'h00, "R8 mask clear drops irq");
        rd_expect(stw(2, 1), 32'h02, "R8 raw unaffected by mask");
        rd_expect(stw(2, 0), 32'h00, "R8 masked cleared");
        wr(fld(1, 5), 32'h04);
        check_irq(8'h04, "R8 mask set restores irq");

        // R6: acknowledge rings owner
        wr(fld(1, 8), 32'h2);
        check_irq(8'h02, "R6 ack rings owner");
        rd_expect(stw(1, 1), 32'h02, "R6 raw status owner");
        rd_expect(stw(2, 1), 32'h00, "R6 destination cleared");

        // R7: illegal code, then idle
        wr(fld(1, 8), 32'h3);
        rd_expect(fld(1, 8), 32'h2, "R7 code 3 ignored");
        check_irq(8'h02, "R7 irq kept after code 3");
        wr(fld(1, 8), 32'h0);
        check_irq(8'h00, "R7 idle drops irq");
        rd_expect(stw(1, 1), 32'h00, "R7 idle clears raw");

        // R10: second mailbox alongside the first
        wr(fld(3, 0), 32'h01);
        wr(fld(3, 1), 32'h04);
        wr(fld(3, 5), 32'h04);
        wr(fld(3, 8), 32'h1);
        wr(fld(1, 8), 32'h1);
        rd_expect(stw(2, 1), 32'h0A, "R9 raw bits per mailbox");
        check_irq(8'h04, "R5 two mailboxes to ch2");
        rd_expect(fld(3, 0), 32'h01, "R10 mailbox 3 owner");
        wr(fld(3, 15), 32'h1234_5678);
        rd_expect(fld(3, 15), 32'h1234_5678, "R10 mailbox 3 data");
        rd_expect(fld(1, 15), 32'hC0DE_0006, "R10 mailbox 1 data kept");

        // R2: release clears bookkeeping
        wr(fld(1, 0), 32'h0);
        rd_expect(fld(1, 3), 32'h0, "R2 release clears dst");
        rd_expect(fld(1, 7), 32'h0, "R2 release clears mask");
        rd_expect(fld(1, 8), 32'h0, "R2 release clears send");
        rd_expect(stw(2, 1), 32'h08, "R2 only mailbox 3 raw");
        wr(fld(1, 0), 32'h10);
        rd_expect(fld(1, 0), 32'h10, "R2 reclaim after release");

        // R10: unmapped words
        wr(fld(1, 4), 32'hFFFF);
        rd_expect(fld(1, 4), 32'h0, "R10 mode reads zero");
        wr(fld(8, 0), 32'h1);
        rd_expect(fld(8, 0), 32'h0, "R10 block past last mailbox");
        rd_expect(stw(8, 0), 32'h0, "R10 status past last channel");
        rd_expect(12'h7FC, 32'h0, "R10 top of mailbox space");

        wr(fld(3, 8), 32'h0);
        check_irq(8'h00, "R7 all idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule